// File: doc/BRIEF.md
# Set-Associative TLB Command Unit

This block is the main translation buffer of a memory management unit. Entries are arranged as sets of ways. Software reaches the buffer through a small register window: two descriptor registers, an index register and a command register.

The first descriptor carries the page-aligned virtual address, a valid bit, a global bit and an 8-bit address-space ID in its low byte. The second descriptor carries the physical frame and the permission flags. The buffer treats the second descriptor as opaque data.

A command written to the command register runs on the following clock edge. The supported commands are:
- probe the buffer;
- pick a slot in the addressed set;
- store the descriptors at the indexed slot, either flushing the small downstream translation caches or leaving them alone;
- read a slot back;
- flush only the downstream caches.

A lookup that matches more than one way raises an overlap fault instead of giving a location. A read-only configuration word reports the version and the geometry.

Top module: `tlbcu_top`

## Requirements
- R1: After reset both descriptor registers and the index register read 0, busy is low, and every entry is invalid, so any probe misses.
- R2: The register window is selected by `reg_addr`. Address 0 is descriptor 0, 1 is descriptor 1, 2 is the index register, 3 is the command register (write only), and 4 is the configuration word (read only). A register write made while busy is high is ignored.
- R3: Command code 1 (probe) searches the set selected by descriptor-0 bits [PAGE_LOG2 +: SETS_LOG2]. On a single match the index register is loaded with set×WAYS+way, and bits 31 and 30 are cleared.
- R4: A probe with no match sets index bit 31 (lookup error). A stored entry matches only when its valid bit 9 is set, its page address bits [31:PAGE_LOG2] are equal, and its ID byte equals descriptor-0 bits [7:0] or its global bit 8 is set.
- R5: Command code 4 (get-index) loads the index register with the lowest-numbered invalid way of the addressed set and clears bits 31:30. When the set is full it uses a victim counter that starts at 0 and advances by one on each such use.
- R6: Command code 2 (write) stores both descriptors at the indexed slot and pulses `utlb_inv` for one cycle. Code 6 stores the descriptors without the pulse. Code 5 pulses `utlb_inv` and leaves storage unchanged.
- R7: A probe that matches two or more ways pulses `overlap_fault` for one cycle and sets both index bit 31 and index bit 30.
- R8: Busy is high for exactly the one cycle between the command write and its execution.
- R9: Command code 3 (read) loads both descriptor registers from the indexed slot.
- R10: Writing zeroes to both descriptors at a slot erases that entry. An entry with the global bit set matches any ID.
- R11: The configuration word holds the version in bits 31:24, log2 of the sets in bits 15:12, log2 of the ways in bits 11:8, log2 of the data-side micro buffer size in bits 7:4, and log2 of the instruction-side micro buffer size in bits 3:0. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| busy | output | 1 | Command accepted, not yet executed |
| utlb_inv | output | 1 | One-cycle flush request to the micro buffers |
| overlap_fault | output | 1 | One-cycle multiple-match fault |

## Verification
A command written at clock edge N raises busy from edge N. It executes at edge N+1. Its index and descriptor results are readable from then on, and `utlb_inv` and `overlap_fault` are high only between edges N+1 and N+2. The bench drives the command at a falling edge and samples busy at the next falling edge. It then samples the pulses and the register window at the falling edge after that. For a read, the window is sampled combinationally, one time step after `reg_addr` changes.

// File: rtl/tlbcu_pkg.sv
package tlbcu_pkg;
    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_PROBE   = 3'd1,
        CMD_WRITE   = 3'd2,
        CMD_READ    = 3'd3,
        CMD_GETIDX  = 3'd4,
        CMD_FLUSHU  = 3'd5,
        CMD_WRITENI = 3'd6
    } tlb_cmd_e;

    localparam int GLOBAL_BIT = 8;
    localparam int VALID_BIT  = 9;
    localparam int ERR_BIT    = 31;
    localparam int DUP_BIT    = 30;

    localparam logic [2:0] RA_PD0   = 3'd0;
    localparam logic [2:0] RA_PD1   = 3'd1;
    localparam logic [2:0] RA_INDEX = 3'd2;
    localparam logic [2:0] RA_CMD   = 3'd3;
    localparam logic [2:0] RA_CFG   = 3'd4;
endpackage

// File: rtl/tlbcu_match.sv
module tlbcu_match #(
    parameter int WAYS      = 2,
    parameter int PAGE_LOG2 = 13
) (
    input  logic [31:0]            key,
    input  logic [WAYS-1:0][31:0]  way_pd0,
    output logic [WAYS-1:0]        hit_vec,
    output logic [WAYS-1:0]        valid_vec
);
    import tlbcu_pkg::*;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic page_eq;
        logic id_ok;
        assign page_eq      = (way_pd0[w][31:PAGE_LOG2] == key[31:PAGE_LOG2]);
        assign id_ok        = way_pd0[w][GLOBAL_BIT] || (way_pd0[w][7:0] == key[7:0]);
        assign valid_vec[w] = way_pd0[w][VALID_BIT];
        assign hit_vec[w]   = valid_vec[w] && page_eq && id_ok;
    end
endmodule

// File: rtl/tlbcu_pick.sv
module tlbcu_pick #(
    parameter int WAYS_LOG2 = 1,
    localparam int WAYS     = 1 << WAYS_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WAYS-1:0]      valid_vec,
    input  logic [WAYS_LOG2-1:0] victim,
    output logic [WAYS_LOG2-1:0] way,
    output logic                 full
);
    always_comb begin
        full = &valid_vec;
        way  = victim;
        if (!full) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!valid_vec[w]) way = WAYS_LOG2'(w);
            end
        end
    end

    assert_pick_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> !valid_vec[way]);
endmodule

// File: rtl/tlbcu_top.sv
module tlbcu_top #(
    parameter int         SETS_LOG2 = 7,
    parameter int         WAYS_LOG2 = 1,
    parameter int         PAGE_LOG2 = 13,
    parameter logic [7:0] VERSION   = 8'h03,
    parameter int         UD_LOG2   = 3,
    parameter int         UI_LOG2   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        busy,
    output logic        utlb_inv,
    output logic        overlap_fault
);
    import tlbcu_pkg::*;

    localparam int WAYS    = 1 << WAYS_LOG2;
    localparam int ENTRIES = 1 << (SETS_LOG2 + WAYS_LOG2);
    localparam int IDX_W   = SETS_LOG2 + WAYS_LOG2;

    typedef struct packed {
        logic [31:0]          pd0;
        logic [31:0]          pd1;
        logic [IDX_W-1:0]     idx;
        logic                 err;
        logic                 dup;
        logic                 pend;
        logic [2:0]           cmd;
        logic [WAYS_LOG2-1:0] victim;
        logic                 inv;
        logic                 fault;
    } state_t;

    state_t s_d, s_q;

    logic [31:0] pd0_mem [ENTRIES];
    logic [31:0] pd1_mem [ENTRIES];
    logic        mem_we;

    logic [SETS_LOG2-1:0]   set_sel;
    logic [WAYS-1:0][31:0]  set_pd0;
    logic [WAYS-1:0]        hit_vec;
    logic [WAYS-1:0]        valid_vec;
    logic [WAYS_LOG2-1:0]   pick_way;
    logic                   set_full;
    logic [WAYS_LOG2-1:0]   hit_way;
    int                     hit_cnt;

    assign set_sel = s_q.pd0[PAGE_LOG2 +: SETS_LOG2];

    for (genvar w = 0; w < WAYS; w++) begin : g_gather
        assign set_pd0[w] = pd0_mem[{set_sel, WAYS_LOG2'(w)}];
    end

    tlbcu_match #(.WAYS(WAYS), .PAGE_LOG2(PAGE_LOG2)) u_match (
        .key(s_q.pd0), .way_pd0(set_pd0), .hit_vec(hit_vec), .valid_vec(valid_vec)
    );

    tlbcu_pick #(.WAYS_LOG2(WAYS_LOG2)) u_pick (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .victim(s_q.victim),
        .way(pick_way), .full(set_full)
    );

    always_comb begin
        hit_cnt = 0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_cnt = hit_cnt + 1;
                hit_way = WAYS_LOG2'(w);
            end
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.inv   = 1'b0;
        s_d.fault = 1'b0;
        mem_we    = 1'b0;
        if (!s_q.pend && reg_wr) begin
            case (reg_addr)
                RA_PD0:   s_d.pd0 = reg_wdata;
                RA_PD1:   s_d.pd1 = reg_wdata;
                RA_INDEX: begin
                    s_d.err = reg_wdata[ERR_BIT];
                    s_d.dup = reg_wdata[DUP_BIT];
                    s_d.idx = reg_wdata[IDX_W-1:0];
                end
                RA_CMD: begin
                    s_d.pend = 1'b1;
                    s_d.cmd  = reg_wdata[2:0];
                end
                default: ;
            endcase
        end
        if (s_q.pend) begin
            s_d.pend = 1'b0;
            case (tlb_cmd_e'(s_q.cmd))
                CMD_PROBE: begin
                    if (hit_cnt == 0) begin
                        s_d.err = 1'b1;
                        s_d.dup = 1'b0;
                    end else if (hit_cnt == 1) begin
                        s_d.idx = {set_sel, hit_way};
                        s_d.err = 1'b0;
                        s_d.dup = 1'b0;
                    end else begin
                        s_d.err   = 1'b1;
                        s_d.dup   = 1'b1;
                        s_d.fault = 1'b1;
                    end
                end
                CMD_WRITE: begin
                    mem_we  = 1'b1;
                    s_d.inv = 1'b1;
                end
                CMD_WRITENI: mem_we = 1'b1;
                CMD_READ: begin
                    s_d.pd0 = pd0_mem[s_q.idx];
                    s_d.pd1 = pd1_mem[s_q.idx];
                end
                CMD_GETIDX: begin
                    s_d.idx = {set_sel, pick_way};
                    s_d.err = 1'b0;
                    s_d.dup = 1'b0;
                    if (set_full) s_d.victim = s_q.victim + 1'b1;
                end
                CMD_FLUSHU: s_d.inv = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                pd0_mem[e] <= '0;
                pd1_mem[e] <= '0;
            end
        end else if (mem_we) begin
            pd0_mem[s_q.idx] <= s_q.pd0;
            pd1_mem[s_q.idx] <= s_q.pd1;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_PD0:   reg_rdata = s_q.pd0;
            RA_PD1:   reg_rdata = s_q.pd1;
            RA_INDEX: reg_rdata = {s_q.err, s_q.dup, (30-IDX_W)'(0), s_q.idx};
            RA_CFG:   reg_rdata = {VERSION, 8'h00, 4'(SETS_LOG2), 4'(WAYS_LOG2),
                                   4'(UD_LOG2), 4'(UI_LOG2)};
            default:  reg_rdata = '0;
        endcase
    end

    assign busy          = s_q.pend;
    assign utlb_inv      = s_q.inv;
    assign overlap_fault = s_q.fault;

    assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    assert_inv_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inv |-> $past(busy));
    assert_fault_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_fault |-> (reg_addr != RA_INDEX || (reg_rdata[ERR_BIT] && reg_rdata[DUP_BIT])));
    assert_fault_after_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_fault |-> $past(busy));
endmodule

// File: tb/sim_tlbcu_top.sv
module sim_tlbcu_top;
    localparam int SL = 2, WL = 1, PL = 12;
    localparam int NW = 1 << WL, NE = 1 << (SL + WL);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, utlb_inv, overlap_fault;

    int total = 0, bad = 0;
    logic inv_s, flt_s, busy_s;

    always #5 clk = ~clk;

    tlbcu_top #(.SETS_LOG2(SL), .WAYS_LOG2(WL), .PAGE_LOG2(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .utlb_inv(utlb_inv), .overlap_fault(overlap_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] c);
        wr(3'd3, {29'd0, c});
        busy_s = busy;
        @(negedge clk);
        inv_s = utlb_inv;
        flt_s = overlap_fault;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] va_of(input int s, input int w);
        return (32'(s * NW + w + 1) << (PL + SL)) | (32'(s) << PL) | 32'h200 | 32'(s * NW + w);
    endfunction

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, v); chk("R1 pd0", v, 0);
        rd(3'd1, v); chk("R1 pd1", v, 0);
        rd(3'd2, v); chk("R1 index", v, 0);
        chk("R1 busy", 32'(busy), 0);
        rd(3'd4, v); chk("R11 cfg", v, {8'h03, 8'h00, 4'(SL), 4'(WL), 4'd3, 4'd2});

        wr(3'd2, 32'h0000_0005);
        rd(3'd2, v); chk("R2 index rw", v, 32'h5);

        wr(3'd0, va_of(1, 0));
        cmd(3'd1);
        chk("R8 busy", 32'(busy_s), 1);
        rd(3'd2, v); chk("R1 R4 empty probe", 32'(v[31]), 1);

        // fill every slot: get-index then write
        for (int s = 0; s < (1 << SL); s++) begin
            for (int w = 0; w < NW; w++) begin
                wr(3'd0, va_of(s, w));
                wr(3'd1, 32'hF000_0000 + 32'(s * NW + w));
                cmd(3'd4);
                rd(3'd2, v); chk("R5 free slot", v, 32'(s * NW + w));
                cmd(3'd2);
                chk("R6 write inv", 32'(inv_s), 1);
            end
        end
        for (int e = 0; e < NE; e++) begin
            wr(3'd0, va_of(e / NW, e % NW));
            cmd(3'd1);
            rd(3'd2, v); chk("R3 probe hit", v, 32'(e));
            chk("R7 no fault", 32'(flt_s), 0);
        end
        for (int e = NE - 1; e >= 0; e--) begin
            wr(3'd2, 32'(e));
            cmd(3'd3);
            rd(3'd0, v); chk("R9 read pd0", v, va_of(e / NW, e % NW));
            rd(3'd1, v); chk("R9 read pd1", v, 32'hF000_0000 + 32'(e));
        end

        wr(3'd0, va_of(2, 1) ^ 32'h0000_0001);
        cmd(3'd1);
        rd(3'd2, v); chk("R4 id mismatch", 32'(v[31]), 1);

        wr(3'd0, 32'h0002_4000);
        cmd(3'd4); rd(3'd2, v); chk("R5 victim 0", v, 32'd0);
        cmd(3'd4); rd(3'd2, v); chk("R5 victim 1", v, 32'd1);

        wr(3'd0, 32'h0002_4355);
        wr(3'd1, 32'h1234_5678);
        cmd(3'd6);
        chk("R6 writeni no inv", 32'(inv_s), 0);
        wr(3'd0, 32'h0002_4077);
        cmd(3'd1);
        rd(3'd2, v); chk("R10 global hit", v, 32'd1);

        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        cmd(3'd2);
        wr(3'd0, 32'h0002_4077);
        cmd(3'd1);
        rd(3'd2, v); chk("R10 erased", 32'(v[31]), 1);

        wr(3'd2, 32'd1);
        wr(3'd0, va_of(0, 0));
        cmd(3'd2);
        cmd(3'd1);
        chk("R7 fault pulse", 32'(flt_s), 1);
        rd(3'd2, v); chk("R7 err dup", {30'd0, v[31:30]}, 32'd3);
        @(negedge clk);
        chk("R7 pulse one cycle", 32'(overlap_fault), 0);

        wr(3'd2, 32'd2);
        cmd(3'd5);
        chk("R6 flush pulse", 32'(inv_s), 1);
        cmd(3'd3);
        rd(3'd0, v); chk("R6 flush keeps", v, va_of(1, 0));

        // write while busy is ignored
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd0;
        @(negedge clk);
        chk("R8 busy set", 32'(busy), 1);
        reg_addr = 3'd0; reg_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 busy clear", 32'(busy), 0);
        rd(3'd0, v); chk("R2 busy ignore", v, va_of(1, 0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule